// File: doc/BRIEF.md
# Split-Chain Array Multiply-Accumulate Unit

This block multiplies two unsigned operands in a single pass through a parallel carry-save array and can add the result into a wide running sum. It forms one partial-product row for each multiplier bit. Rows with an even index reduce along one carry-save chain, and rows with an odd index reduce along a second chain. The two chains work side by side. Their two sum/carry pairs are compressed to one pair only after the array, and a single carry-propagate adder then produces the product. This gives each column about half the adder depth of one long chain.

The operands and controls are captured in an input register stage. The product and the accumulator are registered one stage later, so an operation presented with `in_valid` shows its results two rising edges after it is applied. A clear loads the accumulator with the product alone. An accumulate adds the product into the running sum, which wraps at its width. A sticky flag records any carry out of the accumulator's top bit.

Top module: `mac_oe_top`

## Requirements
- R1: After a synchronous reset, `prod`, `acc` and `acc_ovf` are all zero.
- R2: For an operation applied with `in_valid` high, `prod` equals the unsigned product `op_a * op_b` two rising edges later. This holds for every operand value, including 0, 1 and all ones.
- R3: An input cycle with `in_valid` low leaves `prod` unchanged.
- R4: A valid operation with `acc_clr` high loads `acc` with the zero-extended product and clears `acc_ovf`.
- R5: A valid operation with `acc_en` high and `acc_clr` low sets `acc` to the previous `acc` plus the zero-extended product, modulo 2^ACC_W.
- R6: When `acc_clr` and `acc_en` are both high on a valid operation, the clear takes effect and no addition is made.
- R7: `acc_ovf` becomes 1 when an accumulate produces a carry out of bit ACC_W-1. It then stays 1 until a valid clear.
- R8: When `in_valid` is low, `acc` and `acc_ovf` keep their values, whatever `acc_en` and `acc_clr` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the operands and controls in this cycle |
| op_a | input | A_W | Multiplicand, unsigned |
| op_b | input | B_W | Multiplier, unsigned; its bits select the partial-product rows |
| acc_en | input | 1 | Add the product into the accumulator |
| acc_clr | input | 1 | Load the accumulator with the product; takes priority over acc_en |
| prod | output | A_W+B_W | Registered product |
| acc | output | ACC_W | Registered running sum |
| acc_ovf | output | 1 | Sticky carry-out flag of the accumulator |

## Verification
The assertions assume that reset is held for at least one rising edge before any operation. They also assume that `acc_en` and `acc_clr` have a meaning only in a cycle where `in_valid` is high. A valid cycle with both controls low simply refreshes the product. The stimulus drives operands and controls only through one task. That task applies them for exactly one cycle and then returns every control to its idle level. The stimulus also applies cycles with `in_valid` low and both controls high, to show that such cycles change nothing. The bench runs a small configuration (5 x 5 bits, 12-bit accumulator). Every operand pair is applied, and the accumulator wraps many times.

// File: rtl/mac_oe_pkg.sv
`timescale 1ns/1ps
package mac_oe_pkg;

  // Accumulator action decoded from the registered controls.
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_LOAD = 2'd1,
    ACC_ADD  = 2'd2
  } acc_op_e;

  // Clear outranks accumulate; nothing happens without valid.
  function automatic acc_op_e pick_acc_op(input logic vld, input logic clr,
                                          input logic add);
    if (!vld)     return ACC_HOLD;
    else if (clr) return ACC_LOAD;
    else if (add) return ACC_ADD;
    else          return ACC_HOLD;
  endfunction

endpackage

// File: rtl/mac_csa3.sv
`timescale 1ns/1ps
// Three-input carry-save compressor over a W-bit vector.
module mac_csa3 #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  logic [W-1:0] maj;

  assign s   = x ^ y ^ z;
  assign maj = (x & y) | (x & z) | (y & z);
  assign c   = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/mac_oe_chain.sv
`timescale 1ns/1ps
// One carry-save chain taking every second partial-product row,
// starting at row PHASE (0 = even rows, 1 = odd rows).
module mac_oe_chain #(
  parameter int A_W   = 16,
  parameter int B_W   = 16,
  parameter int PHASE = 0
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] sum_o,
  output logic [A_W+B_W-1:0] car_o
);
  localparam int PW = A_W + B_W;
  localparam int NR = (B_W - PHASE + 1) / 2;

  logic [PW-1:0] row [NR];
  logic [PW-1:0] s   [NR];
  logic [PW-1:0] c   [NR];

  for (genvar k = 0; k < NR; k++) begin : g_row
    localparam int IDX = PHASE + 2 * k;
    assign row[k] = {{B_W{1'b0}}, (a & {A_W{b[IDX]}})} << IDX;

    if (k == 0) begin : g_head
      assign s[k] = row[k];
      assign c[k] = '0;
    end else begin : g_stage
      mac_csa3 #(.W(PW)) u_csa (
        .x(s[k-1]),
        .y(c[k-1]),
        .z(row[k]),
        .s(s[k]),
        .c(c[k])
      );
    end
  end

  assign sum_o = s[NR-1];
  assign car_o = c[NR-1];
endmodule

// File: rtl/mac_oe_merge.sv
`timescale 1ns/1ps
// Folds the two chain results (four vectors) into two, then one
// carry-propagate addition yields the product.
module mac_oe_merge #(
  parameter int PW = 32
) (
  input  logic [PW-1:0] ev_s,
  input  logic [PW-1:0] ev_c,
  input  logic [PW-1:0] od_s,
  input  logic [PW-1:0] od_c,
  output logic [PW-1:0] prod
);
  logic [PW-1:0] s1, c1, s2, c2;

  mac_csa3 #(.W(PW)) u_lvl1 (
    .x(ev_s), .y(ev_c), .z(od_s), .s(s1), .c(c1)
  );

  mac_csa3 #(.W(PW)) u_lvl2 (
    .x(s1), .y(c1), .z(od_c), .s(s2), .c(c2)
  );

  assign prod = s2 + c2;
endmodule

// File: rtl/mac_oe_acc.sv
`timescale 1ns/1ps
// Running-sum register with sticky carry-out flag.
module mac_oe_acc #(
  parameter int PW    = 32,
  parameter int ACC_W = 35
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             add,
  input  logic             clr,
  input  logic [PW-1:0]    prod_in,
  output logic [ACC_W-1:0] acc_q,
  output logic             ovf_q
);
  import mac_oe_pkg::*;

  localparam int EXT = ACC_W - PW;

  acc_op_e          op;
  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W:0]   sum_w;

  assign op       = pick_acc_op(vld, clr, add);
  assign prod_ext = {{EXT{1'b0}}, prod_in};
  assign sum_w    = {1'b0, acc_q} + {1'b0, prod_ext};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      unique case (op)
        ACC_LOAD: begin
          acc_q <= prod_ext;
          ovf_q <= 1'b0;
        end
        ACC_ADD: begin
          acc_q <= sum_w[ACC_W-1:0];
          ovf_q <= ovf_q | sum_w[ACC_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mac_oe_top.sv
`timescale 1ns/1ps
// Two-stage multiply-accumulate: input capture, then split-chain
// array, merge and accumulate into registered outputs.
module mac_oe_top #(
  parameter int A_W   = 16,
  parameter int B_W   = 16,
  parameter int ACC_W = 35
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [A_W-1:0]       op_a,
  input  logic [B_W-1:0]       op_b,
  input  logic                 acc_en,
  input  logic                 acc_clr,
  output logic [A_W+B_W-1:0]   prod,
  output logic [ACC_W-1:0]     acc,
  output logic                 acc_ovf
);
  localparam int PW = A_W + B_W;

  // Stage 1: capture
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           v_q, en_q, clr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      v_q   <= 1'b0;
      en_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      v_q   <= in_valid;
      en_q  <= in_valid & acc_en;
      clr_q <= in_valid & acc_clr;
      if (in_valid) begin
        a_q <= op_a;
        b_q <= op_b;
      end
    end
  end

  // Array: even and odd chains in parallel
  logic [PW-1:0] ev_s, ev_c, od_s, od_c, prod_w;

  mac_oe_chain #(.A_W(A_W), .B_W(B_W), .PHASE(0)) u_even (
    .a(a_q), .b(b_q), .sum_o(ev_s), .car_o(ev_c)
  );

  mac_oe_chain #(.A_W(A_W), .B_W(B_W), .PHASE(1)) u_odd (
    .a(a_q), .b(b_q), .sum_o(od_s), .car_o(od_c)
  );

  mac_oe_merge #(.PW(PW)) u_merge (
    .ev_s(ev_s), .ev_c(ev_c), .od_s(od_s), .od_c(od_c), .prod(prod_w)
  );

  // Stage 2: product and accumulator registers
  always_ff @(posedge clk) begin
    if (rst)      prod <= '0;
    else if (v_q) prod <= prod_w;
  end

  mac_oe_acc #(.PW(PW), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .vld(v_q), .add(en_q), .clr(clr_q),
    .prod_in(prod_w), .acc_q(acc), .ovf_q(acc_ovf)
  );
endmodule

// File: rtl/mac_oe_checks.sv
`timescale 1ns/1ps
module mac_oe_checks #(
  parameter int A_W   = 16,
  parameter int B_W   = 16,
  parameter int ACC_W = 35
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 v_q,
  input logic                 en_q,
  input logic                 clr_q,
  input logic [A_W-1:0]       a_q,
  input logic [B_W-1:0]       b_q,
  input logic [A_W+B_W-1:0]   prod,
  input logic [ACC_W-1:0]     acc,
  input logic                 acc_ovf
);
  localparam int PW = A_W + B_W;

  logic [ACC_W-1:0] prod_ext;
  logic [PW-1:0]    ref_mul;
  assign prod_ext = {{(ACC_W-PW){1'b0}}, prod};
  assign ref_mul  = PW'(a_q) * PW'(b_q);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (prod == '0 && acc == '0 && !acc_ovf));

  p_prod_r2: assert property (@(posedge clk) disable iff (rst)
    v_q |=> prod == $past(ref_mul));

  p_prod_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !v_q |=> $stable(prod));

  p_clr_load_r4: assert property (@(posedge clk) disable iff (rst)
    (v_q && clr_q) |=> (acc == prod_ext && !acc_ovf));

  p_add_r5: assert property (@(posedge clk) disable iff (rst)
    (v_q && en_q && !clr_q) |=> (acc - $past(acc)) == prod_ext);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_ovf && !(v_q && clr_q)) |=> acc_ovf);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !v_q |=> ($stable(acc) && $stable(acc_ovf)));
endmodule

bind mac_oe_top mac_oe_checks #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .v_q(v_q), .en_q(en_q), .clr_q(clr_q),
  .a_q(a_q), .b_q(b_q), .prod(prod), .acc(acc), .acc_ovf(acc_ovf)
);

// File: tb/sim_mac_oe_top.sv
`timescale 1ns/1ps
module sim_mac_oe_top;
  localparam int TA   = 5;
  localparam int TB   = 5;
  localparam int TACC = 12;
  localparam int TP   = TA + TB;
  localparam int MODV = 1 << TACC;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [TA-1:0]   op_a = '0;
  logic [TB-1:0]   op_b = '0;
  logic            acc_en = 1'b0;
  logic            acc_clr = 1'b0;
  logic [TP-1:0]   prod;
  logic [TACC-1:0] acc;
  logic            acc_ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int exp_prod = 0;
  int exp_acc  = 0;
  bit exp_ovf  = 1'b0;

  always #2 clk = ~clk;

  mac_oe_top #(.A_W(TA), .B_W(TB), .ACC_W(TACC)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_en(acc_en), .acc_clr(acc_clr), .prod(prod), .acc(acc),
    .acc_ovf(acc_ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One operation, held for one cycle; results sampled after the
  // second rising edge.
  task automatic do_op(input int a, input int b, input bit v,
                       input bit en, input bit cl);
    int sum;
    @(negedge clk);
    op_a = TA'(a); op_b = TB'(b); in_valid = v; acc_en = en; acc_clr = cl;
    @(negedge clk);
    in_valid = 1'b0; acc_en = 1'b0; acc_clr = 1'b0;
    @(posedge clk); #1;
    if (v) begin
      exp_prod = a * b;
      if (cl) begin                       // R4, R6
        exp_acc = exp_prod;
        exp_ovf = 1'b0;
      end else if (en) begin              // R5, R7
        sum = exp_acc + exp_prod;
        if (sum >= MODV) exp_ovf = 1'b1;
        exp_acc = sum % MODV;
      end
    end
    chk(v ? "R2 product" : "R3 product hold", int'(prod), exp_prod);
    chk(!v ? "R8 acc idle" : (cl ? (en ? "R6 clear wins" : "R4 clear load")
                                 : "R5 accumulate"), int'(acc), exp_acc);
    chk(!v ? "R8 flag idle" : "R7 overflow flag", int'(acc_ovf), int'(exp_ovf));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset prod", int'(prod), 0);
    chk("R1 reset acc", int'(acc), 0);
    chk("R1 reset ovf", int'(acc_ovf), 0);
    @(negedge clk); rst = 1'b0;

    // R2 corner operands: zero, one, all ones
    do_op(0, 31, 1, 0, 1);
    do_op(1, 1, 1, 0, 1);
    do_op(31, 31, 1, 1, 0);
    do_op(31, 1, 1, 1, 0);
    do_op(1, 31, 1, 1, 1);   // R6
    do_op(7, 9, 0, 1, 1);    // R3, R8: ignored controls

    // Exhaustive sweep with accumulation, periodic clears and idles
    for (int a = 0; a < (1 << TA); a++) begin
      for (int b = 0; b < (1 << TB); b++) begin
        int idx = a * (1 << TB) + b;
        do_op(a, b, 1, 1, (idx % 97) == 0);
        if ((idx % 61) == 0) do_op(b, a, 0, idx[0], 1);
      end
    end

    // R7: force wrap, confirm flag survives a small add, then clears
    do_op(31, 31, 1, 0, 1);
    for (int i = 0; i < 6; i++) do_op(31, 31, 1, 1, 0);
    do_op(1, 0, 1, 1, 0);
    do_op(2, 3, 1, 0, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule